// File: doc/BRIEF.md
# Rotate-Mask-Shift Unit

This block is the bit-manipulation datapath of an integer execution pipeline. One left rotator and one mask generator serve every operation it offers. The operations are rotate-and-mask, rotate-and-insert, logical left and right shifts, arithmetic right shifts with a carry flag, and sign-extend-then-shift-left. Each can run on the full doubleword of `DW` bits or on the low word of `DW/2` bits. A word operation copies the low half into both halves before it rotates. A mask that wraps across the half boundary then still yields the correct bits.

The two clear controls pick the operation form. Both clear controls set gives a rotate with a begin bound and an end bound. Clear-left alone gives a begin bound only. Clear-right alone gives an end bound only. Neither set gives a shift.

Mask bound positions are counted from the most significant bit: position 0 is bit `DW-1`. A mask covers the positions from begin through end. When end is lower than begin, the mask wraps around. Mask bits pick rotated source bits. The other bits take the insert operand, or the sign bit during an arithmetic shift. The result and the carry are registered, so they appear one clock after the inputs are sampled.

Top module: `rms_unit`

## Requirements
- R1: While `rst_n` is low, `res_o` and `carry_o` are zero. Inputs sampled at a rising edge appear on the outputs after that edge.
- R2: Rotate form, both clear controls set, doubleword mode. Result = (rotl(src, sh mod DW) & M) | (ins & ~M). M covers positions `mb` through `me`, counted from the MSB. It wraps through position DW-1 and back to position 0 when `me` < `mb`.
- R3: With clear-left alone, the mask runs from `mb` to position DW-1. With clear-right alone, it runs from position 0 to `me`.
- R4: In word mode, rotate forms use the low half copied into both halves. The bounds are DW/2 plus the low log2(DW)-1 bits of `mb` and `me`.
- R5: Result bits outside the mask take the insert operand `ins_i`.
- R6: Logical doubleword shifts, with `ins_i` zero, shift by `sh_i`. Any amount of DW or more gives zero.
- R7: Logical word shifts use only the low log2(DW) bits of `sh_i`. Amounts of DW/2 or more give zero. The upper half of the result is zero.
- R8: Arithmetic right doubleword shifts fill with bit DW-1. Amounts of DW or more give all copies of the sign bit.
- R9: An arithmetic right word shift works on the low half, with bit DW/2-1 as the sign. It sign-extends the low-half result through the upper half.
- R10: `carry_o` is one only for an arithmetic right shift of a negative source in which at least one 1 bit was shifted out. It is zero for every other operation.
- R11: With `sext_i` set, a doubleword left shift first extends bit DW/2-1 through the upper half, then shifts.
- R12: An arithmetic right shift ignores `ins_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | DW | Source operand |
| ins_i | input | DW | Insert operand for bits outside the mask |
| sh_i | input | log2(DW)+1 | Rotate or shift amount |
| mb_i | input | log2(DW) | Mask begin position |
| me_i | input | log2(DW) | Mask end position |
| word_i | input | 1 | Word mode |
| right_i | input | 1 | Shift right (shift form only) |
| arith_i | input | 1 | Arithmetic fill with sign |
| clr_left_i | input | 1 | Use begin bound |
| clr_right_i | input | 1 | Use end bound |
| sext_i | input | 1 | Sign-extend the low half before a doubleword shift |
| res_o | output | DW | Registered result |
| carry_o | output | 1 | Registered arithmetic-shift carry |

## Verification
The assertions for zero results and for a zero upper half on logical shifts hold only when the insert operand is zero. Those properties include a zero insert operand in their antecedents, and the bench drives zero for every logical shift. The assertions also assume that arithmetic fill is requested only together with a right shift. The stimulus follows that rule and runs arithmetic only on right shifts. There it drives a non-zero insert operand to show that the operand is ignored.

// File: rtl/rms_pkg.sv
package rms_pkg;

  typedef enum logic [1:0] {
    FORM_SHIFT = 2'b00,
    FORM_CLRR  = 2'b01,
    FORM_CLRL  = 2'b10,
    FORM_BOTH  = 2'b11
  } rms_form_e;

  function automatic rms_form_e rms_form(input logic clr_left, input logic clr_right);
    return rms_form_e'({clr_left, clr_right});
  endfunction

endpackage

// File: rtl/rms_prep.sv
module rms_prep #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] src,
  input  logic          word_mode,
  input  logic          sext,
  output logic [DW-1:0] data,
  output logic          sign
);
  localparam int HW = DW / 2;

  always_comb begin
    if (word_mode)
      data = {src[HW-1:0], src[HW-1:0]};
    else if (sext)
      data = {{HW{src[HW-1]}}, src[HW-1:0]};
    else
      data = src;
    sign = word_mode ? src[HW-1] : src[DW-1];
  end
endmodule

// File: rtl/rms_rotl.sv
module rms_rotl #(
  parameter int DW = 64,
  localparam int LW = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [LW-1:0] amt,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] stage [0:LW];

  assign stage[0] = din;

  for (genvar k = 0; k < LW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stage[k+1] = amt[k] ? {stage[k][DW-1-D:0], stage[k][DW-1:DW-D]} : stage[k];
  end

  assign dout = stage[LW];
endmodule

// File: rtl/rms_mask.sv
module rms_mask
  import rms_pkg::*;
#(
  parameter int DW = 64,
  localparam int LW = $clog2(DW),
  localparam int SW = LW + 1
) (
  input  rms_form_e     form,
  input  logic [LW-1:0] mb,
  input  logic [LW-1:0] me,
  input  logic [SW-1:0] sh,
  input  logic          word_mode,
  input  logic          right,
  output logic [DW-1:0] mask,
  output logic          over
);
  // Positions count from the MSB; wraps when end < begin.
  function automatic logic [DW-1:0] span(input logic [LW-1:0] b, input logic [LW-1:0] e);
    logic [DW-1:0] from_b, upto_e;
    from_b = {DW{1'b1}} >> b;
    upto_e = ~(({DW{1'b1}} >> e) >> 1);
    return (b <= e) ? (from_b & upto_e) : (from_b | upto_e);
  endfunction

  logic [LW-1:0] bnd_b, bnd_e, amt, pos_b, pos_e;

  always_comb begin
    bnd_b = word_mode ? {1'b1, mb[LW-2:0]} : mb;
    bnd_e = word_mode ? {1'b1, me[LW-2:0]} : me;
    amt   = word_mode ? {1'b0, sh[LW-2:0]} : sh[LW-1:0];
    over  = 1'b0;
    unique case (form)
      FORM_BOTH: begin pos_b = bnd_b; pos_e = bnd_e; end
      FORM_CLRL: begin pos_b = bnd_b; pos_e = {LW{1'b1}}; end
      FORM_CLRR: begin pos_b = '0;    pos_e = bnd_e; end
      default: begin
        over = word_mode ? sh[LW-1] : sh[LW];
        if (right) begin
          pos_b = word_mode ? {1'b1, amt[LW-2:0]} : amt;
          pos_e = {LW{1'b1}};
        end else begin
          pos_b = word_mode ? {1'b1, {(LW-1){1'b0}}} : '0;
          pos_e = ~amt;
        end
      end
    endcase
    mask = over ? '0 : span(pos_b, pos_e);
  end
endmodule

// File: rtl/rms_unit.sv
module rms_unit
  import rms_pkg::*;
#(
  parameter int DW = 64,
  localparam int LW = $clog2(DW),
  localparam int SW = LW + 1,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] ins_i,
  input  logic [SW-1:0] sh_i,
  input  logic [LW-1:0] mb_i,
  input  logic [LW-1:0] me_i,
  input  logic          word_i,
  input  logic          right_i,
  input  logic          arith_i,
  input  logic          clr_left_i,
  input  logic          clr_right_i,
  input  logic          sext_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o
);
  rms_form_e     form;
  logic          shift_form;
  logic [DW-1:0] prep_data, rot_data, mask, fill, region, lost_bits, res_d;
  logic [LW-1:0] rot_amt;
  logic          src_sign, amt_over, carry_d;

  assign form       = rms_form(clr_left_i, clr_right_i);
  assign shift_form = (form == FORM_SHIFT);
  assign rot_amt    = (shift_form && right_i) ? (LW'(0) - sh_i[LW-1:0]) : sh_i[LW-1:0];

  rms_prep #(.DW(DW)) u_prep (
    .src(src_i), .word_mode(word_i), .sext(sext_i), .data(prep_data), .sign(src_sign)
  );

  rms_rotl #(.DW(DW)) u_rotl (
    .din(prep_data), .amt(rot_amt), .dout(rot_data)
  );

  rms_mask #(.DW(DW)) u_mask (
    .form(form), .mb(mb_i), .me(me_i), .sh(sh_i), .word_mode(word_i),
    .right(right_i), .mask(mask), .over(amt_over)
  );

  assign fill      = arith_i ? {DW{src_sign}} : ins_i;
  assign region    = word_i ? {{HW{1'b0}}, {HW{1'b1}}} : {DW{1'b1}};
  assign lost_bits = rot_data & ~mask & region;
  assign carry_d   = shift_form & right_i & arith_i & src_sign & (|lost_bits);
  assign res_d     = (rot_data & mask) | (fill & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      res_o   <= res_d;
      carry_o <= carry_d;
    end
  end
endmodule

// File: rtl/rms_unit_chk.sv
module rms_unit_chk #(
  parameter int DW = 64,
  localparam int HW = DW / 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shift_form,
  input logic          word_i,
  input logic          right_i,
  input logic          arith_i,
  input logic          src_sign,
  input logic          amt_over,
  input logic [DW-1:0] ins_i,
  input logic [DW-1:0] res_o,
  input logic          carry_o
);
  logic ashr;
  assign ashr = shift_form && right_i && arith_i;

  assert_over_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_form && !arith_i && amt_over && ins_i == '0) |=> res_o == '0);

  assert_carry_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ashr && !src_sign) |=> !carry_o);

  assert_carry_only_ashr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ashr |=> !carry_o);

  assert_ashr_over_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ashr && amt_over && src_sign) |=> (res_o == {DW{1'b1}} && carry_o));

  assert_word_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_form && word_i && !arith_i && ins_i == '0) |=> res_o[DW-1:HW] == '0);

  assert_word_ashr_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ashr && word_i) |=> res_o[DW-1:HW] == {HW{res_o[HW-1]}});
endmodule

bind rms_unit rms_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_form(shift_form), .word_i(word_i),
  .right_i(right_i), .arith_i(arith_i), .src_sign(src_sign), .amt_over(amt_over),
  .ins_i(ins_i), .res_o(res_o), .carry_o(carry_o)
);

// File: tb/tb_rms_unit.sv
module tb_rms_unit;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [15:0] src, ins, res;
  logic [4:0]  sh;
  logic [3:0]  mb, me;
  logic        word, right, arith, cl, cr, sext, carry;
  int n_chk = 0, n_err = 0;

  rms_unit #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .ins_i(ins), .sh_i(sh), .mb_i(mb), .me_i(me),
    .word_i(word), .right_i(right), .arith_i(arith), .clr_left_i(cl), .clr_right_i(cr),
    .sext_i(sext), .res_o(res), .carry_o(carry)
  );

  task automatic chk16(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] span16(input int b, input int e);
    logic [15:0] m = '0;
    for (int p = 0; p < 16; p++)
      if ((b <= e) ? (p >= b && p <= e) : (p >= b || p <= e)) m[15-p] = 1'b1;
    return m;
  endfunction

  function automatic logic [15:0] exp_rot(input logic [15:0] s, input logic [15:0] in,
      input int a, input int b, input int e, input bit w, input bit l, input bit r);
    logic [15:0] d = w ? {s[7:0], s[7:0]} : s;
    logic [31:0] t = {d, d} << (a % 16);
    int bb = w ? 8 + b % 8 : b;
    int ee = w ? 8 + e % 8 : e;
    logic [15:0] m;
    if (l && !r) ee = 15;
    if (r && !l) bb = 0;
    m = span16(bb, ee);
    return (t[31:16] & m) | (in & ~m);
  endfunction

  task automatic apply(input logic [15:0] s, input logic [15:0] in, input int a, input int b,
      input int e, input bit w, input bit rt, input bit ar, input bit l, input bit r, input bit sx);
    src = s; ins = in; sh = 5'(a); mb = 4'(b); me = 4'(e);
    word = w; right = rt; arith = ar; cl = l; cr = r; sext = sx;
    @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    logic [15:0] pats [7];
    pats = '{16'h8001, 16'h7ff0, 16'hB3C5, 16'h0080, 16'hFFFF, 16'h1234, 16'h00F1};
    rst_n = 1'b0;
    apply(16'hBEEF, 16'h1111, 3, 1, 2, 0, 1, 1, 0, 0, 0);
    apply(16'hBEEF, 16'h1111, 3, 1, 2, 0, 1, 1, 0, 0, 0);
    chk16("R1 reset result", res, 16'h0);
    chk1("R1 reset carry", carry, 1'b0);
    rst_n = 1'b1;

    // R2 / R5: both bounds, doubleword, wrap, insert merge
    for (int pi = 0; pi < 2; pi++)
      for (int b = 0; b < 16; b++)
        for (int e = 0; e < 16; e++)
          for (int a = 0; a < 16; a++) begin
            logic [15:0] s = pi ? 16'hB3C5 : 16'h0F31;
            logic [15:0] in = pi ? 16'h0000 : 16'hA55A;
            apply(s, in, a, b, e, 0, 0, 0, 1, 1, 0);
            chk16(pi ? "R2 rotate-mask" : "R5 rotate-insert", res, exp_rot(s, in, a, b, e, 0, 1, 1));
            chk1("R10 no carry on rotate", carry, 1'b0);
          end

    // R3: single-bound forms
    for (int k = 0; k < 16; k++)
      for (int a = 0; a < 16; a++) begin
        apply(16'hC3A5, 16'h0, a, k, 5, 0, 0, 0, 1, 0, 0);
        chk16("R3 clear-left", res, exp_rot(16'hC3A5, 16'h0, a, k, 5, 0, 1, 0));
        apply(16'hC3A5, 16'h0, a, 9, k, 0, 0, 0, 0, 1, 0);
        chk16("R3 clear-right", res, exp_rot(16'hC3A5, 16'h0, a, 9, k, 0, 0, 1));
      end

    // R4: word rotate-mask with wrapping bounds; upper amount bits ignored
    for (int b = 0; b < 8; b++)
      for (int e = 0; e < 8; e++)
        for (int a = 0; a < 32; a++) begin
          apply(16'h5A96, 16'h0, a, b, e, 1, 0, 0, 1, 1, 0);
          chk16("R4 word rotate", res, exp_rot(16'h5A96, 16'h0, a, b, e, 1, 1, 1));
        end

    // Shifts R6..R12
    for (int pi = 0; pi < 7; pi++)
      for (int a = 0; a < 32; a++) begin
        logic [15:0] s = pats[pi];
        logic [7:0]  lo = s[7:0];
        logic [15:0] ex, lost;
        logic signed [15:0] sd = s;
        logic signed [7:0]  sw = lo;
        logic signed [7:0]  qw;
        int aw = a % 16;

        apply(s, 16'h0, a, 0, 0, 0, 0, 0, 0, 0, 0);
        ex = (a >= 16) ? 16'h0 : 16'(s << a);
        chk16("R6 doubleword left", res, ex);
        apply(s, 16'h0, a, 0, 0, 0, 1, 0, 0, 0, 0);
        ex = (a >= 16) ? 16'h0 : (s >> a);
        chk16("R6 doubleword right", res, ex);
        chk1("R10 no carry logical", carry, 1'b0);

        apply(s, 16'h0, a, 0, 0, 1, 0, 0, 0, 0, 0);
        ex = (aw >= 8) ? 16'h0 : {8'h0, 8'(lo << aw)};
        chk16("R7 word left", res, ex);
        apply(s, 16'h0, a, 0, 0, 1, 1, 0, 0, 0, 0);
        ex = (aw >= 8) ? 16'h0 : {8'h0, lo >> aw};
        chk16("R7 word right", res, ex);

        apply(s, 16'h5A5A, a, 0, 0, 0, 1, 1, 0, 0, 0);
        ex = 16'(sd >>> ((a > 15) ? 15 : a));
        chk16("R8 R12 doubleword arith", res, ex);
        lost = (a >= 16) ? s : (s & 16'((1 << a) - 1));
        chk1("R10 doubleword carry", carry, s[15] && lost != 0);

        apply(s, 16'h5A5A, a, 0, 0, 1, 1, 1, 0, 0, 0);
        qw = sw >>> ((aw > 7) ? 7 : aw);
        chk16("R9 R12 word arith", res, {{8{qw[7]}}, qw});
        lost = (aw >= 8) ? {8'h0, lo} : {8'h0, lo & 8'((1 << aw) - 1)};
        chk1("R10 word carry", carry, lo[7] && lost != 0);

        apply(s, 16'h0, a, 0, 0, 0, 0, 0, 0, 0, 1);
        ex = (a >= 16) ? 16'h0 : 16'({{8{lo[7]}}, lo} << a);
        chk16("R11 sign-extend shift", res, ex);
      end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule